// File: doc/BRIEF.md
# Bidirectional LCD Common Scan Register

This block walks a single select bit across the common rows of a dot-matrix LCD panel. A chain of row stages is advanced by an external shift clock. That clock is sampled by the block's own system clock, and a static input chooses whether its rising or its falling edge is active. A direction input decides which end pin feeds the chain and which end pin passes the bit on to the next device. This lets several devices be cascaded in either orientation.

Every row presents a 2-bit level code to the analog output stage. The code is formed from the row's stage bit and the AC-inversion input. A selected row (bit 1) maps to one of the two select levels. An idle row maps to one of the two non-select levels. The inversion input picks the polarity in both cases.

The level codes are: 00 is V1 (select, M=0), 01 is V2 (select, M=1), 10 is V5 (non-select, M=0), and 11 is V6 (non-select, M=1). Row r uses bits [2r-1:2r-2] of the row code bus, and row 1 sits at bits [1:0].

Top module: `lcd_com_scan`

## Requirements
- R1: While reset is asserted and after it is released, before any active shift edge, every row carries code 10 (V5 with M=0) and both end pins `dl_o` and `dr_o` read 0.
- R2: With `shl_i`=1, each active edge loads `dl_i` into row 1 and moves row k to row k+1.
- R3: With `shl_i`=0, each active edge loads `dr_i` into the last row and moves row k to row k-1.
- R4: With `fcs_i`=1, only a rising edge of `cl2_i` shifts; a falling edge leaves all rows unchanged. With `fcs_i`=0, only a falling edge shifts; a rising edge leaves all rows unchanged.
- R5: With `m_i`=1, a row whose bit is 1 shows code 01 (V2) and a row whose bit is 0 shows code 11 (V6).
- R6: With `m_i`=0, a row whose bit is 1 shows code 00 (V1) and a row whose bit is 0 shows code 10 (V5).
- R7: Row codes change exactly 1 clock after a change of `m_i`, and exactly 4 clocks after an active `cl2_i` edge (2 synchroniser stages, 1 stage update, 1 code register).
- R8: With `shl_i`=1, `dr_oe_o`=1, `dl_oe_o`=0, `dr_o` carries the last row's bit and `dl_o` is 0. With `shl_i`=0 the roles mirror, and `dl_o` carries row 1's bit. Both pins are registered and follow the stage bit with the same latency as the row codes.
- R9: When no active edge occurs, the stage contents hold through any number of clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cl2_i | input | 1 | Asynchronous shift clock |
| fcs_i | input | 1 | Edge select: 1 rising, 0 falling |
| shl_i | input | 1 | Direction: 1 left-to-right, 0 right-to-left |
| m_i | input | 1 | AC inversion signal |
| dl_i | input | 1 | Left end serial input |
| dr_i | input | 1 | Right end serial input |
| dl_o | output | 1 | Left end serial output |
| dl_oe_o | output | 1 | Left end output enable |
| dr_o | output | 1 | Right end serial output |
| dr_oe_o | output | 1 | Right end output enable |
| row_code_o | output | 2*N_ROWS | Per-row level codes, row 1 in bits [1:0] |

## Verification
After an active `cl2_i` edge, the row codes and the end pins change on the fourth clock. After an `m_i` change they change on the first clock, and after an `shl_i` change the enables and pins change on the first clock. The driver pushes one expected item for every clock that follows an edge stimulus, so the monitor sees the old value up to the cycle before the update and the new value on the exact cycle. This also catches a design that is one cycle early or late. For the other stimuli, the driver lets the outputs settle before pushing a single expected snapshot.

// File: rtl/lcd_com_pkg.sv
package lcd_com_pkg;
  typedef enum logic [1:0] {
    LVL_V1 = 2'b00,
    LVL_V2 = 2'b01,
    LVL_V5 = 2'b10,
    LVL_V6 = 2'b11
  } lvl_e;

  function automatic lvl_e lvl_code(input logic row_bit, input logic m);
    case ({row_bit, m})
      2'b10:   return LVL_V1;
      2'b11:   return LVL_V2;
      2'b00:   return LVL_V5;
      default: return LVL_V6;
    endcase
  endfunction
endpackage

// File: rtl/cl2_edge_det.sv
module cl2_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cl2_i,
  input  logic fcs_i,
  output logic shift_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q[0] <= cl2_i;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise    = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall    = ~sync_q[SYNC_STAGES-1] & prev_q;
  assign shift_o = fcs_i ? rise : fall;

  // R4
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |=> !shift_o);
endmodule

// File: rtl/com_shift_reg.sv
module com_shift_reg #(
  parameter int N_ROWS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              dir_i,
  input  logic              din_l_i,
  input  logic              din_r_i,
  output logic [N_ROWS-1:0] stage_o
);
  logic [N_ROWS-1:0] stage_q;
  logic [N_ROWS-1:0] stage_d;

  for (genvar g = 0; g < N_ROWS; g++) begin : g_stage
    logic from_left, from_right;
    if (g == 0) begin : g_first
      assign from_left = din_l_i;
    end else begin : g_mid_l
      assign from_left = stage_q[g-1];
    end
    if (g == N_ROWS-1) begin : g_last
      assign from_right = din_r_i;
    end else begin : g_mid_r
      assign from_right = stage_q[g+1];
    end
    assign stage_d[g] = dir_i ? from_left : from_right;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[g] <= 1'b0;
      else if (shift_i) stage_q[g] <= stage_d[g];
    end
  end

  assign stage_o = stage_q;

  // R2
  shl_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && dir_i) |=> (stage_q[0] == $past(din_l_i)) &&
                           (stage_q[N_ROWS-1] == $past(stage_q[N_ROWS-2])));
  // R3
  shr_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !dir_i) |=> (stage_q[N_ROWS-1] == $past(din_r_i)) &&
                            (stage_q[0] == $past(stage_q[1])));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(stage_q));
endmodule

// File: rtl/row_level_enc.sv
module row_level_enc
  import lcd_com_pkg::*;
#(
  parameter int N_ROWS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_ROWS-1:0]   bits_i,
  input  logic                m_i,
  output logic [2*N_ROWS-1:0] codes_o
);
  for (genvar g = 0; g < N_ROWS; g++) begin : g_row
    lvl_e code_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) code_q <= LVL_V5;
      else         code_q <= lvl_code(bits_i[g], m_i);
    end
    assign codes_o[2*g +: 2] = code_q;
  end

  // R7
  first_row_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> codes_o[1:0] == {~$past(bits_i[0]), $past(m_i)});
  // R5
  sel_m1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_i && bits_i[N_ROWS-1]) |=> codes_o[2*N_ROWS-1 -: 2] == 2'b01);
endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan #(
  parameter int N_ROWS      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cl2_i,
  input  logic                fcs_i,
  input  logic                shl_i,
  input  logic                m_i,
  input  logic                dl_i,
  input  logic                dr_i,
  output logic                dl_o,
  output logic                dl_oe_o,
  output logic                dr_o,
  output logic                dr_oe_o,
  output logic [2*N_ROWS-1:0] row_code_o
);
  localparam int LAST = N_ROWS - 1;

  logic              shift;
  logic [N_ROWS-1:0] stage;

  cl2_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cl2_i  (cl2_i),
    .fcs_i  (fcs_i),
    .shift_o(shift)
  );

  com_shift_reg #(.N_ROWS(N_ROWS)) u_sreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift),
    .dir_i  (shl_i),
    .din_l_i(dl_i),
    .din_r_i(dr_i),
    .stage_o(stage)
  );

  row_level_enc #(.N_ROWS(N_ROWS)) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bits_i (stage),
    .m_i    (m_i),
    .codes_o(row_code_o)
  );

  // End pins: the downstream end drives, the idle end reads 0.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dl_o    <= 1'b0;
      dr_o    <= 1'b0;
      dl_oe_o <= 1'b0;
      dr_oe_o <= 1'b0;
    end else begin
      dr_oe_o <= shl_i;
      dl_oe_o <= ~shl_i;
      dr_o    <= shl_i  & stage[LAST];
      dl_o    <= ~shl_i & stage[0];
    end
  end

  // R8
  dir_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shl_i |=> dr_oe_o && !dl_oe_o);
  // R8
  idle_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dr_oe_o |-> !dr_o);
  // R8
  oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dl_oe_o && dr_oe_o));
endmodule

// File: tb/lcd_com_scan_tb.sv
module lcd_com_scan_tb;
  localparam int N = 64;

  typedef struct {
    logic [2*N-1:0] codes;
    logic           dl, dr, dl_oe, dr_oe;
    string          tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic cl2 = 0, fcs = 1, shl = 1, m = 0, dl_in = 0, dr_in = 0;
  logic dl_out, dl_oe, dr_out, dr_oe;
  logic [2*N-1:0] codes;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [N-1:0] model = '0;
  item_t q[$];

  always #10 clk = ~clk;

  lcd_com_scan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cl2_i(cl2), .fcs_i(fcs), .shl_i(shl),
    .m_i(m), .dl_i(dl_in), .dr_i(dr_in), .dl_o(dl_out), .dl_oe_o(dl_oe),
    .dr_o(dr_out), .dr_oe_o(dr_oe), .row_code_o(codes)
  );

  function automatic item_t snap(string tag);
    item_t it;
    for (int r = 0; r < N; r++) it.codes[2*r +: 2] = {~model[r], m};
    it.dr_oe = shl;
    it.dl_oe = ~shl;
    it.dr    = shl & model[N-1];
    it.dl    = ~shl & model[0];
    it.tag   = tag;
    return it;
  endfunction

  task automatic push(item_t it);
    q.push_back(it);
  endtask

  task automatic settle(string tag);
    repeat (6) @(negedge clk);
    push(snap(tag));
  endtask

  // Drive a CL2 level; track each following clock to check latency.
  task automatic set_cl2(logic v, string tag);
    item_t old_it, new_it;
    bit active;
    @(negedge clk);
    old_it = snap(tag);
    active = (fcs && !cl2 && v) || (!fcs && cl2 && !v);
    cl2 = v;
    if (active) begin
      if (shl) model = {model[N-2:0], dl_in};
      else     model = {dr_in, model[N-1:1]};
    end
    new_it = snap(tag);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      push(k < 4 ? old_it : new_it);
    end
  endtask

  task automatic pulse(logic din, string tag);
    if (shl) dl_in = din; else dr_in = din;
    set_cl2(~cl2, tag);
    set_cl2(~cl2, tag);
  endtask

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (codes !== e.codes || dl_out !== e.dl || dr_out !== e.dr ||
            dl_oe !== e.dl_oe || dr_oe !== e.dr_oe) begin
          errors++;
          $display("FAIL %s: codes=%h dl=%b dr=%b oe=%b%b exp codes=%h dl=%b dr=%b oe=%b%b",
                   e.tag, codes, dl_out, dr_out, dl_oe, dr_oe,
                   e.codes, e.dl, e.dr, e.dl_oe, e.dr_oe);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, exp done=1 got 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    item_t it;
    // R1 during reset
    repeat (3) @(negedge clk);
    it = snap("R1 in reset");
    it.dl_oe = 0; it.dr_oe = 0;
    push(it);
    @(negedge clk);
    rst_n = 1;
    settle("R1 after reset");

    // R2 R4 R7: rising edges, walk a 1 from the left
    fcs = 1; shl = 1; m = 1;
    settle("R5 idle rows V6");
    pulse(1'b1, "R2 R7 load row1");
    pulse(1'b0, "R2 shift");
    pulse(1'b1, "R2 shift pattern");
    for (int i = 0; i < N - 3; i++) pulse(1'b0, "R2 walk");
    settle("R8 dr_o carries last row");
    pulse(1'b0, "R2 bit leaves right end");
    settle("R5 R6 pattern M=1");

    // R6 R7: M change latency
    @(negedge clk);
    m = 0;
    it = snap("R7 M latency");
    @(negedge clk);
    push(it);
    settle("R6 M=0 codes");

    // R4: falling edge mode, rising ignored
    fcs = 0;
    dl_in = 1;
    set_cl2(1'b1, "R4 rise ignored at FCS=0");
    set_cl2(1'b0, "R4 fall shifts at FCS=0");
    settle("R9 hold without edges");
    repeat (20) @(negedge clk);
    push(snap("R9 hold long"));

    // R4: rising mode, falling ignored
    fcs = 1;
    dl_in = 1;
    set_cl2(1'b1, "R4 rise shifts at FCS=1");
    dl_in = 0;
    set_cl2(1'b0, "R4 fall ignored at FCS=1");

    // R3 R8: reverse direction
    @(negedge clk);
    shl = 0;
    it = snap("R8 enable swap");
    @(negedge clk);
    push(it);
    settle("R8 dl_o driven");
    pulse(1'b1, "R3 load last row");
    for (int i = 0; i < N + 2; i++) pulse(i == 5, "R3 walk");
    m = 1;
    settle("R3 R5 final");

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule